// File: doc/BRIEF.md
# Soft-Value Scaler for a Fixed-Point Turbo Decoder

This block prepares soft values for the component decoders of a fixed-point turbo decoder. It works in two modes. In channel mode it multiplies a received sample by a reliability weight that is always a power of two. In extrinsic mode it multiplies the soft value that one component decoder hands to the other by three quarters. There is no multiplier in the block. Power-of-two weights are shifts, and the three-quarter factor is a shift and an add.

Input samples are 8-bit two's complement with 2 fractional bits. Results are 6-bit two's complement with 2 fractional bits. Every result is rounded and then clamped to a symmetric range. The block also emits a hard decision taken from the sign of the result. Transfers use a valid/ready handshake on both sides. The mode and the shift exponent travel with each input beat, so one stream can mix channel and extrinsic items.

Top module: `soft_value_scaler`

## Requirements
- R1: During reset and on the first cycle after reset, out_valid is low, out_value is 0 and in_ready is high.
- R2: In channel mode (in_mode = 0), an exponent x in 0..2 gives out_value = in_sample * 2^x, counted in the same 2-fractional-bit units. Saturation as in R6 applies.
- R3: In channel mode, a negative exponent x gives in_sample / 2^(-x), rounded to the nearest integer unit. A tie rounds away from zero: 5 with x = -1 gives 3, and -5 gives -3.
- R4: in_exp is a 3-bit two's complement number. Values above +2 act as +2 and values below -2 act as -2.
- R5: In extrinsic mode (in_mode = 1), out_value = 0.75 * in_sample, rounded to nearest with ties away from zero. For example, 2 gives 2, -6 gives -5 and 3 gives 2. in_exp has no effect in this mode.
- R6: Results beyond the output range clamp to +31 or -31. The code -32 never appears.
- R7: out_bit is 1 exactly when out_value is greater than zero, and 0 otherwise.
- R8: An input accepted on a clock edge appears on the output after that same edge. One input can be accepted every cycle. When no input is accepted and the output is taken, out_valid drops.
- R9: While out_valid is high and out_ready is low, in_ready is low, out_value and out_bit hold steady, and a presented input is not taken until the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_mode | input | 1 | 0 selects channel scaling, 1 selects extrinsic scaling |
| in_exp | input | 3 | Signed power-of-two exponent for channel mode |
| in_sample | input | 8 | Signed soft input, 2 fractional bits |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 6 | Signed scaled result, 2 fractional bits |
| out_bit | output | 1 | Hard decision, 1 when the result is positive |

## Verification
The only state in the block is the output register, together with its valid flag. A wrong value from the rounding, clamping or exponent path therefore shows up on out_value on the cycle right after the beat is accepted. A handshake fault shows up at once in other ways. The valid flag may stay set too long or drop too early. The held value may change while stalled. A beat presented during a stall may be lost or taken twice. Each of these is visible within one or two cycles of the stall starting or ending.

// File: rtl/ssq_pkg.sv
`timescale 1ns/1ps
package ssq_pkg;
  typedef enum logic {
    SSQ_CHANNEL   = 1'b0,
    SSQ_EXTRINSIC = 1'b1
  } ssq_mode_e;
endpackage

// File: rtl/ssq_exp_clamp.sv
`timescale 1ns/1ps
// Limits the signed exponent to the supported window.
module ssq_exp_clamp #(
  parameter int EXP_W  = 3,
  parameter int EXP_LO = -2,
  parameter int EXP_HI = 2
) (
  input  logic signed [EXP_W-1:0] exp_raw,
  output logic signed [EXP_W-1:0] exp_sat
);
  localparam logic signed [EXP_W-1:0] LO_V = EXP_W'(EXP_LO);
  localparam logic signed [EXP_W-1:0] HI_V = EXP_W'(EXP_HI);

  always_comb begin
    if (exp_raw < LO_V)      exp_sat = LO_V;
    else if (exp_raw > HI_V) exp_sat = HI_V;
    else                     exp_sat = exp_raw;
  end
endmodule

// File: rtl/ssq_prescale.sv
`timescale 1ns/1ps
// Forms the widened numerator and the pending right-shift amount.
module ssq_prescale
  import ssq_pkg::*;
#(
  parameter int IN_W    = 8,
  parameter int EXP_W   = 3,
  parameter int WIDE_W  = 13,
  parameter int RSH_W   = 2,
  parameter int EXTR_SH = 2
) (
  input  ssq_mode_e                mode,
  input  logic signed [IN_W-1:0]   sample,
  input  logic signed [EXP_W-1:0]  exp_sat,
  output logic signed [WIDE_W-1:0] num,
  output logic [RSH_W-1:0]         rsh
);
  logic signed [WIDE_W-1:0] wide;
  assign wide = WIDE_W'(sample);

  always_comb begin
    num = wide;
    rsh = '0;
    if (mode == SSQ_EXTRINSIC) begin
      // three quarters: 3*v, then divide by four in the rounder
      num = (wide <<< 1) + wide;
      rsh = RSH_W'(EXTR_SH);
    end else if (exp_sat[EXP_W-1] == 1'b0) begin
      num = wide <<< $unsigned(exp_sat);
    end else begin
      rsh = RSH_W'($unsigned(-exp_sat));
    end
  end
endmodule

// File: rtl/ssq_round_sat.sv
`timescale 1ns/1ps
// Sign-magnitude rounding (ties away from zero) and symmetric clamp.
module ssq_round_sat #(
  parameter int WIDE_W  = 13,
  parameter int OUT_W   = 6,
  parameter int MAX_RSH = 2,
  parameter int RSH_W   = 2
) (
  input  logic signed [WIDE_W-1:0] num,
  input  logic [RSH_W-1:0]         rsh,
  output logic signed [OUT_W-1:0]  res
);
  localparam logic [WIDE_W-1:0] LIM_W   = WIDE_W'(2**(OUT_W-1) - 1);
  localparam logic [OUT_W-1:0]  LIM_N   = OUT_W'(2**(OUT_W-1) - 1);
  localparam logic [RSH_W-1:0]  RSH_TOP = RSH_W'(MAX_RSH);

  logic              neg;
  logic [WIDE_W-1:0] mag;
  logic [WIDE_W-1:0] cand [MAX_RSH+1];
  logic [WIDE_W-1:0] sel;
  logic [OUT_W-1:0]  clipped;

  assign neg = num[WIDE_W-1];
  assign mag = neg ? -num : num;

  for (genvar k = 0; k <= MAX_RSH; k++) begin : g_rnd
    if (k == 0) begin : g_pass
      assign cand[k] = mag;
    end else begin : g_shift
      localparam logic [WIDE_W-1:0] HALF = WIDE_W'(1) << (k - 1);
      assign cand[k] = (mag + HALF) >> k;
    end
  end

  always_comb begin
    sel     = (rsh > RSH_TOP) ? cand[MAX_RSH] : cand[rsh];
    clipped = (sel > LIM_W) ? LIM_N : sel[OUT_W-1:0];
    res     = neg ? -clipped : clipped;
  end
endmodule

// File: rtl/soft_value_scaler.sv
`timescale 1ns/1ps
module soft_value_scaler
  import ssq_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 6,
  parameter int EXP_W  = 3,
  parameter int EXP_LO = -2,
  parameter int EXP_HI = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_mode,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_value,
  output logic                    out_bit
);
  localparam int EXTR_SH = 2;
  localparam int WIDE_W  = IN_W + EXP_HI + 3;
  localparam int MAX_RSH = (-EXP_LO > EXTR_SH) ? -EXP_LO : EXTR_SH;
  localparam int RSH_W   = $clog2(MAX_RSH + 1);

  ssq_mode_e                mode;
  logic signed [EXP_W-1:0]  exp_sat;
  logic signed [WIDE_W-1:0] num;
  logic [RSH_W-1:0]         rsh;
  logic signed [OUT_W-1:0]  res;
  logic                     accept;

  assign mode     = ssq_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  ssq_exp_clamp #(.EXP_W(EXP_W), .EXP_LO(EXP_LO), .EXP_HI(EXP_HI)) u_clamp (
    .exp_raw (in_exp),
    .exp_sat (exp_sat)
  );

  ssq_prescale #(
    .IN_W(IN_W), .EXP_W(EXP_W), .WIDE_W(WIDE_W), .RSH_W(RSH_W), .EXTR_SH(EXTR_SH)
  ) u_pre (
    .mode    (mode),
    .sample  (in_sample),
    .exp_sat (exp_sat),
    .num     (num),
    .rsh     (rsh)
  );

  ssq_round_sat #(
    .WIDE_W(WIDE_W), .OUT_W(OUT_W), .MAX_RSH(MAX_RSH), .RSH_W(RSH_W)
  ) u_rs (
    .num (num),
    .rsh (rsh),
    .res (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_bit   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_value <= res;
        out_bit   <= !res[OUT_W-1] && (|res);
      end
    end
  end
endmodule

// File: rtl/ssq_checker.sv
`timescale 1ns/1ps
module ssq_checker #(
  parameter int OUT_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_value,
  input logic                    out_bit
);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_value != MOST_NEG);

  assert_hard_sign_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bit == (out_value > 0)));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_bit)));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind soft_value_scaler ssq_checker #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_value (out_value),
  .out_bit   (out_bit)
);

// File: tb/tb_soft_value_scaler.sv
`timescale 1ns/1ps
module tb_soft_value_scaler;
  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid, in_ready, in_mode;
  logic signed [2:0] in_exp;
  logic signed [7:0] in_sample;
  logic              out_valid, out_ready, out_bit;
  logic signed [5:0] out_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  soft_value_scaler dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_exp(in_exp), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_bit(out_bit)
  );

  // {mode, exp, sample, expected}
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,  3'sd1,  8'sd5,   6'sd10},  // R2
    {1'b0,  3'sd0, -8'sd7,  -6'sd7},   // R2
    {1'b0,  3'sd2,  8'sd7,   6'sd28},  // R2
    {1'b0,  3'sd2,  8'sd8,   6'sd31},  // R6
    {1'b0,  3'sd2, -8'sd8,  -6'sd31},  // R6
    {1'b0, -3'sd1,  8'sd5,   6'sd3},   // R3
    {1'b0, -3'sd1, -8'sd5,  -6'sd3},   // R3
    {1'b0, -3'sd2,  8'sd6,   6'sd2},   // R3
    {1'b0, -3'sd2, -8'sd6,  -6'sd2},   // R3
    {1'b0, -3'sd2,  8'sd5,   6'sd1},   // R3
    {1'b0,  3'sd3,  8'sd3,   6'sd12},  // R4
    {1'b0,  3'b100, 8'sd9,   6'sd2},   // R4
    {1'b0, -3'sd3, -8'sd10, -6'sd3},   // R4
    {1'b1,  3'sd0,  8'sd4,   6'sd3},   // R5
    {1'b1,  3'sd0,  8'sd2,   6'sd2},   // R5
    {1'b1,  3'sd0, -8'sd2,  -6'sd2},   // R5
    {1'b1,  3'sd0,  8'sd1,   6'sd1},   // R5
    {1'b1,  3'sd0, -8'sd1,  -6'sd1},   // R5
    {1'b1,  3'sd0,  8'sd100, 6'sd31},  // R6
    {1'b1,  3'sd0,  8'h80,  -6'sd31},  // R6
    {1'b1,  3'sd0,  8'sd40,  6'sd30},  // R5
    {1'b1,  3'sd0,  8'sd41,  6'sd31},  // R5
    {1'b1,  3'sd2,  8'sd8,   6'sd6},   // R5 exponent ignored
    {1'b1, -3'sd2,  8'sd8,   6'sd6},   // R5 exponent ignored
    {1'b0,  3'sd0,  8'sd127, 6'sd31},  // R6
    {1'b0,  3'sd0,  8'h80,  -6'sd31},  // R6
    {1'b0,  3'sd0,  8'sd0,   6'sd0},   // R2
    {1'b1,  3'sd0,  8'sd3,   6'sd2},   // R5
    {1'b1,  3'sd0, -8'sd3,  -6'sd2},   // R5
    {1'b1,  3'sd0, -8'sd6,  -6'sd5}    // R5
  };

  function automatic string req_of(int i);
    if (i < 3)  return "R2";
    if (i < 5)  return "R6";
    if (i < 10) return "R3";
    if (i < 13) return "R4";
    if (i < 18) return "R5";
    if (i < 20) return "R6";
    if (i < 24) return "R5";
    if (i < 26) return "R6";
    if (i == 26) return "R2";
    return "R5";
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic drive(logic m, logic signed [2:0] e, logic signed [7:0] s);
    in_valid  = 1'b1;
    in_mode   = m;
    in_exp    = e;
    in_sample = s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_exp = '0; in_sample = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "out_value in reset", int'(out_value), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    // Table walk, streamed one beat per cycle (R8 throughput and latency)
    for (int k = 0; k <= NV; k++) begin
      if (k > 0) begin
        logic signed [5:0] ev;
        ev = VEC[k-1][5:0];
        chk("R8", $sformatf("out_valid vec %0d", k-1), int'(out_valid), 1);
        chk(req_of(k-1), $sformatf("value vec %0d", k-1), int'(out_value), int'(ev));
        chk("R7", $sformatf("hard bit vec %0d", k-1), int'(out_bit), int'(ev > 0));
      end
      if (k < NV) begin
        chk("R8", "in_ready while streaming", int'(in_ready), 1);
        drive(VEC[k][17], VEC[k][16:14], VEC[k][13:6]);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    // R8: no accepted input, output drained
    chk("R8", "out_valid after drain", int'(out_valid), 0);

    // R9: stall behaviour
    out_ready = 1'b0;
    drive(1'b0, 3'sd0, 8'sd9);
    @(negedge clk);
    chk("R9", "stall out_valid", int'(out_valid), 1);
    chk("R9", "stall value", int'(out_value), 9);
    drive(1'b0, 3'sd0, 8'sd20);
    for (int j = 0; j < 3; j++) begin
      chk("R9", "in_ready low while stalled", int'(in_ready), 0);
      @(negedge clk);
      chk("R9", "held value", int'(out_value), 9);
      chk("R9", "held valid", int'(out_valid), 1);
      chk("R9", "held hard bit", int'(out_bit), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", "pending input taken after release", int'(out_value), 20);
    chk("R9", "valid after release", int'(out_valid), 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "out_valid drops when idle", int'(out_valid), 0);

    // R1: reset in the middle of traffic
    drive(1'b1, 3'sd0, -8'sd12);
    @(negedge clk);
    chk("R5", "extrinsic -12", int'(out_value), -9);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after mid reset", int'(out_valid), 0);
    chk("R1", "out_value after mid reset", int'(out_value), 0);
    chk("R1", "in_ready after mid reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule